// File: doc/BRIEF.md
# Direct Interrupt Line Router

This block gives selected GPIO pins a private interrupt wire to the host, so that they skip the shared summary interrupt. It has M output lines. Each line has a configuration word. The word names one of N pins, sets the active level of that pin and holds a processor target code. A line is driven only when its target code names the host and the named pin is marked for direct routing. Every output is active-high, so a pin that is active-low is inverted on the way out.

Each pin has a routing word with a direct-route flag and a target code. Each pin also has two normal-interrupt enables, which the neighbouring detection logic reads. Software reaches these words through a single-cycle write port. An install command performs the full binding of a pin to a line in one cycle. Pins are synchronised, and the line outputs are registered, so the outputs never glitch.

Top module: `dcr_router`

## Requirements
- R1: While reset is held and on the first cycle after it, all line outputs and all per-pin state outputs are zero.
- R2: With polarity bit set, the host target code 4 and the selected pin's direct-route flag set, a line equals its selected pin.
- R3: With polarity bit clear and the line otherwise enabled, a line equals the inverse of its selected pin.
- R4: A line whose target code is anything other than 4 stays low whatever its pin does.
- R5: A line stays low while the direct-route flag of its selected pin is clear.
- R6: A line whose pin field holds a value of N or above stays low.
- R7: A pin change that is set up before rising edge k shows on a bound line after edge k+2 and not before it.
- R8: An accepted install of pin p on line l sets p's direct-route flag with target code 7 and clears both of p's normal-interrupt enables. It writes line l with target 4, pin field p and the requested polarity. An install request blocks a register write in the same cycle.
- R9: An install whose pin index is N or above, or whose line index is M or above, changes no state.
- R10: A register write whose index is out of range for its kind changes no state.
- R11: Encodings. Write kind 0 selects a line word, kind 1 a pin routing word and kind 2 a pin interrupt word. In a line word, bits [2:0] are the target, [10:3] the pin and 11 the polarity. In a routing word, bit 3 is the direct-route flag and [2:0] the target. In an interrupt word, bit 0 is the interrupt enable and bit 3 the raw-status enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | N_PINS | Asynchronous pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register kind (0 line, 1 routing, 2 interrupt) |
| wr_idx | input | 8 | Line or pin index of the write |
| wr_data | input | 12 | Write data |
| inst_req | input | 1 | Install command strobe |
| inst_pin | input | 8 | Pin to install |
| inst_line | input | 8 | Line to install on |
| inst_pol | input | 1 | Install polarity, 1 for active-high |
| dc_line | output | N_LINES | Direct interrupt lines, active high |
| pin_dc_en | output | N_PINS | Per-pin direct-route flags |
| pin_tgt | output | 3*N_PINS | Per-pin target codes, pin p at [3p+2:3p] |
| pin_irq_en | output | N_PINS | Per-pin normal interrupt enables |
| pin_raw_en | output | N_PINS | Per-pin raw-status enables |

## Verification
A register write or install takes effect at the rising edge on which it is presented, so the per-pin outputs are due one edge later. A line output follows a new configuration one edge after that. A pin change passes two synchroniser stages and the output register, so it is due after the third rising edge. The bench drives every stimulus on a falling edge and waits three rising edges before it compares, which covers all of these delays. The R7 check alone samples after the second and after the third edge, to pin down the exact cycle.

// File: rtl/dcr_pkg.sv
`timescale 1ns/1ps
package dcr_pkg;
  localparam int SEL_W = 8;
  localparam int CFG_W = 12;
  localparam logic [2:0] TGT_HOST = 3'd4;
  localparam logic [2:0] TGT_NONE = 3'd7;

  typedef enum logic [1:0] {
    KIND_LINE  = 2'd0,
    KIND_ROUTE = 2'd1,
    KIND_INTR  = 2'd2
  } wr_kind_e;

  typedef struct packed {
    logic             pol;
    logic [SEL_W-1:0] pin;
    logic [2:0]       tgt;
  } line_cfg_t;

  function automatic logic line_enabled(logic [2:0] tgt, logic in_range, logic dc_en);
    return (tgt == TGT_HOST) && in_range && dc_en;
  endfunction

  function automatic logic line_level(logic pin_val, logic pol, logic enabled);
    return enabled & (pin_val ~^ pol);
  endfunction

  function automatic line_cfg_t install_word(logic [SEL_W-1:0] pin, logic pol);
    line_cfg_t c;
    c.pol = pol;
    c.pin = pin;
    c.tgt = TGT_HOST;
    return c;
  endfunction
endpackage

// File: rtl/dcr_sync.sv
`timescale 1ns/1ps
module dcr_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [1:0]   warm;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
      warm   <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
      if (warm != 2'd2) warm <= warm + 2'd1;
    end
  end

  // R7
  sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/dcr_regs.sv
`timescale 1ns/1ps
module dcr_regs
  import dcr_pkg::*;
#(
  parameter int N_PINS  = 16,
  parameter int N_LINES = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  wr_kind_e                     wr_kind,
  input  logic [7:0]                   wr_idx,
  input  logic [CFG_W-1:0]             wr_data,
  input  logic                         inst_req,
  input  logic [7:0]                   inst_pin,
  input  logic [7:0]                   inst_line,
  input  logic                         inst_pol,
  output line_cfg_t [N_LINES-1:0]      line_cfg,
  output logic [N_PINS-1:0]            dc_en,
  output logic [N_PINS-1:0][2:0]       route_tgt,
  output logic [N_PINS-1:0]            irq_en,
  output logic [N_PINS-1:0]            raw_en
);
  localparam logic [8:0] PIN_LIM  = 9'(N_PINS);
  localparam logic [8:0] LINE_LIM = 9'(N_LINES);

  logic inst_ok, wr_ok;
  assign inst_ok = inst_req && ({1'b0, inst_pin} < PIN_LIM) && ({1'b0, inst_line} < LINE_LIM);
  assign wr_ok   = wr_en && !inst_req;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        dc_en[p]     <= 1'b0;
        route_tgt[p] <= 3'd0;
        irq_en[p]    <= 1'b0;
        raw_en[p]    <= 1'b0;
      end else if (inst_ok && inst_pin == 8'(p)) begin
        dc_en[p]     <= 1'b1;
        route_tgt[p] <= TGT_NONE;
        irq_en[p]    <= 1'b0;
        raw_en[p]    <= 1'b0;
      end else if (wr_ok && wr_idx == 8'(p)) begin
        if (wr_kind == KIND_ROUTE) begin
          dc_en[p]     <= wr_data[3];
          route_tgt[p] <= wr_data[2:0];
        end else if (wr_kind == KIND_INTR) begin
          irq_en[p] <= wr_data[0];
          raw_en[p] <= wr_data[3];
        end
      end
    end
  end

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        line_cfg[l] <= '0;
      end else if (inst_ok && inst_line == 8'(l)) begin
        line_cfg[l] <= install_word(inst_pin, inst_pol);
      end else if (wr_ok && wr_kind == KIND_LINE && wr_idx == 8'(l)) begin
        line_cfg[l] <= line_cfg_t'(wr_data);
      end
    end
  end

  // R8
  install_apply_chk: assert property (@(posedge clk) disable iff (rst)
    inst_ok |=> (dc_en[$past(inst_pin)] && !irq_en[$past(inst_pin)] &&
                 !raw_en[$past(inst_pin)] &&
                 line_cfg[$past(inst_line)].tgt == TGT_HOST));

  // R9
  install_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (inst_req && !inst_ok) |=> ($stable(line_cfg) && $stable(dc_en) &&
                                $stable(irq_en) && $stable(raw_en)));

  // R10
  line_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !inst_req && wr_kind == KIND_LINE && {1'b0, wr_idx} >= LINE_LIM)
      |=> $stable(line_cfg));
endmodule

// File: rtl/dcr_line.sv
`timescale 1ns/1ps
module dcr_line
  import dcr_pkg::*;
#(
  parameter int N_PINS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  line_cfg_t         cfg,
  input  logic [N_PINS-1:0] pins_s,
  input  logic [N_PINS-1:0] dc_en,
  output logic              line_q
);
  localparam int PIN_IW = (N_PINS > 1) ? $clog2(N_PINS) : 1;
  localparam logic [8:0] PIN_LIM = 9'(N_PINS);

  logic              sel_ok;
  logic [PIN_IW-1:0] sel_idx;
  logic              sel_val, sel_dc, gate_ok;

  assign sel_ok  = {1'b0, cfg.pin} < PIN_LIM;
  assign sel_idx = cfg.pin[PIN_IW-1:0];
  assign sel_val = sel_ok ? pins_s[sel_idx] : 1'b0;
  assign sel_dc  = sel_ok ? dc_en[sel_idx]  : 1'b0;
  assign gate_ok = line_enabled(cfg.tgt, sel_ok, sel_dc);

  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b0;
    else     line_q <= line_level(sel_val, cfg.pol, gate_ok);
  end

  // R4, R5, R6
  gated_low_chk: assert property (@(posedge clk) disable iff (rst)
    !gate_ok |=> !line_q);
endmodule

// File: rtl/dcr_router.sv
`timescale 1ns/1ps
module dcr_router
  import dcr_pkg::*;
#(
  parameter int N_PINS  = 16,
  parameter int N_LINES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_PINS-1:0]     pin_in,
  input  logic                  wr_en,
  input  logic [1:0]            wr_kind,
  input  logic [7:0]            wr_idx,
  input  logic [11:0]           wr_data,
  input  logic                  inst_req,
  input  logic [7:0]            inst_pin,
  input  logic [7:0]            inst_line,
  input  logic                  inst_pol,
  output logic [N_LINES-1:0]    dc_line,
  output logic [N_PINS-1:0]     pin_dc_en,
  output logic [3*N_PINS-1:0]   pin_tgt,
  output logic [N_PINS-1:0]     pin_irq_en,
  output logic [N_PINS-1:0]     pin_raw_en
);
  logic [N_PINS-1:0]        pins_s;
  line_cfg_t [N_LINES-1:0]  line_cfg;
  logic [N_PINS-1:0][2:0]   route_tgt;
  logic                     rst_d;

  dcr_sync #(.W(N_PINS)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pins_s)
  );

  dcr_regs #(.N_PINS(N_PINS), .N_LINES(N_LINES)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_kind(wr_kind_e'(wr_kind)), .wr_idx(wr_idx), .wr_data(wr_data),
    .inst_req(inst_req), .inst_pin(inst_pin), .inst_line(inst_line), .inst_pol(inst_pol),
    .line_cfg(line_cfg), .dc_en(pin_dc_en), .route_tgt(route_tgt),
    .irq_en(pin_irq_en), .raw_en(pin_raw_en)
  );

  for (genvar p = 0; p < N_PINS; p++) begin : g_tgt
    assign pin_tgt[3*p +: 3] = route_tgt[p];
  end

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    dcr_line #(.N_PINS(N_PINS)) u_line (
      .clk(clk), .rst(rst), .cfg(line_cfg[l]), .pins_s(pins_s),
      .dc_en(pin_dc_en), .line_q(dc_line[l])
    );
  end

  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d) begin
      // R1
      reset_clear_chk: assert (dc_line == '0 && pin_dc_en == '0 &&
                               pin_irq_en == '0 && pin_raw_en == '0 && pin_tgt == '0)
        else $error("reset state not clear");
    end
  end
endmodule

// File: tb/test_dcr_router.sv
`timescale 1ns/1ps
module test_dcr_router;
  localparam int N = 16;
  localparam int M = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] pin_in = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_kind = '0;
  logic [7:0] wr_idx = '0;
  logic [11:0] wr_data = '0;
  logic inst_req = 1'b0;
  logic [7:0] inst_pin = '0, inst_line = '0;
  logic inst_pol = 1'b0;
  logic [M-1:0] dc_line;
  logic [N-1:0] pin_dc_en, pin_irq_en, pin_raw_en;
  logic [3*N-1:0] pin_tgt;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [11:0] s_line [M];
  logic [N-1:0] s_dc, s_irq, s_raw;
  logic [2:0] s_tgt [N];

  always #2.5 clk = ~clk;

  dcr_router #(.N_PINS(N), .N_LINES(M)) i_dcr_router (
    .clk(clk), .rst(rst), .pin_in(pin_in), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_idx(wr_idx), .wr_data(wr_data), .inst_req(inst_req), .inst_pin(inst_pin),
    .inst_line(inst_line), .inst_pol(inst_pol), .dc_line(dc_line),
    .pin_dc_en(pin_dc_en), .pin_tgt(pin_tgt), .pin_irq_en(pin_irq_en),
    .pin_raw_en(pin_raw_en)
  );

  function automatic logic exp_one(int l);
    logic [11:0] c = s_line[l];
    int p = int'(c[10:3]);
    if (p >= N) return 1'b0;
    if (c[2:0] != 3'd4) return 1'b0;
    if (!s_dc[p]) return 1'b0;
    return c[11] ? pin_in[p] : !pin_in[p];
  endfunction

  function automatic logic [M-1:0] exp_lines();
    logic [M-1:0] v;
    for (int l = 0; l < M; l++) v[l] = exp_one(l);
    return v;
  endfunction

  function automatic logic [3*N-1:0] exp_tgt();
    logic [3*N-1:0] v;
    for (int p = 0; p < N; p++) v[3*p +: 3] = s_tgt[p];
    return v;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "lines", 64'(dc_line), 64'(exp_lines()));
    chk(tag, "dc_en", 64'(pin_dc_en), 64'(s_dc));
    chk(tag, "tgt", 64'(pin_tgt), 64'(exp_tgt()));
    chk(tag, "irq_en", 64'(pin_irq_en), 64'(s_irq));
    chk(tag, "raw_en", 64'(pin_raw_en), 64'(s_raw));
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(logic [1:0] k, int idx, logic [11:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = k; wr_idx = 8'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (k == 2'd0 && idx < M) s_line[idx] = d;
    if (k == 2'd1 && idx < N) begin s_dc[idx] = d[3]; s_tgt[idx] = d[2:0]; end
    if (k == 2'd2 && idx < N) begin s_irq[idx] = d[0]; s_raw[idx] = d[3]; end
  endtask

  task automatic shadow_install(int p, int l, logic pol);
    if (p < N && l < M) begin
      s_dc[p] = 1'b1; s_tgt[p] = 3'd7; s_irq[p] = 1'b0; s_raw[p] = 1'b0;
      s_line[l] = {pol, 8'(p), 3'd4};
    end
  endtask

  task automatic do_install(int p, int l, logic pol);
    @(negedge clk);
    inst_req = 1'b1; inst_pin = 8'(p); inst_line = 8'(l); inst_pol = pol;
    @(negedge clk);
    inst_req = 1'b0;
    shadow_install(p, l, pol);
  endtask

  task automatic set_pin(int p, logic v);
    @(negedge clk);
    pin_in[p] = v;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < M; l++) s_line[l] = '0;
    for (int p = 0; p < N; p++) s_tgt[p] = '0;
    s_dc = '0; s_irq = '0; s_raw = '0;
    void'($urandom(32'd4242));
    pin_in = 16'hFFFF;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R1");

    // R2: active-high binding of pin 5 on line 0
    do_write(2'd1, 5, 12'h008);
    do_write(2'd0, 0, {1'b1, 8'd5, 3'd4});
    set_pin(5, 1'b1); settle(); check_all("R2");
    set_pin(5, 1'b0); settle(); check_all("R2");
    // R3: inverted
    do_write(2'd0, 0, {1'b0, 8'd5, 3'd4});
    settle(); check_all("R3");
    chk("R3", "line0 high when pin low", 64'(dc_line[0]), 64'(1));
    set_pin(5, 1'b1); settle(); check_all("R3");
    // R4: target not host
    do_write(2'd0, 0, {1'b0, 8'd5, 3'd7});
    set_pin(5, 1'b0); settle(); check_all("R4");
    chk("R4", "line0 gated", 64'(dc_line[0]), 64'(0));
    // R5: direct-route flag clear
    do_write(2'd0, 0, {1'b1, 8'd5, 3'd4});
    set_pin(5, 1'b1);
    do_write(2'd1, 5, 12'h004);
    settle(); check_all("R5");
    chk("R5", "line0 gated", 64'(dc_line[0]), 64'(0));
    // R6: out-of-range pin fields, inverted polarity would be high if not gated
    do_write(2'd0, 1, {1'b0, 8'd16, 3'd4}); settle(); check_all("R6");
    do_write(2'd0, 1, {1'b0, 8'd200, 3'd4}); settle(); check_all("R6");
    chk("R6", "line1 gated", 64'(dc_line[1]), 64'(0));
    // R11 + R8: interrupt word then install clears it
    do_write(2'd2, 3, 12'h009); settle(); check_all("R11");
    set_pin(3, 1'b0);
    do_install(3, 2, 1'b1); settle(); check_all("R8");
    // R7: exact latency
    @(negedge clk); pin_in[3] = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R7", "line2 before third edge", 64'(dc_line[2]), 64'(0));
    @(posedge clk); @(negedge clk);
    chk("R7", "line2 after third edge", 64'(dc_line[2]), 64'(1));
    // R9: rejected installs
    do_install(16, 0, 1'b0); settle(); check_all("R9");
    do_install(2, 4, 1'b0); settle(); check_all("R9");
    // R10: out-of-range writes
    do_write(2'd0, 4, 12'hFFC); do_write(2'd1, 16, 12'h008);
    do_write(2'd2, 16, 12'h009); settle(); check_all("R10");
    // R8: install wins over a write in the same cycle
    @(negedge clk);
    inst_req = 1'b1; inst_pin = 8'd7; inst_line = 8'd3; inst_pol = 1'b0;
    wr_en = 1'b1; wr_kind = 2'd1; wr_idx = 8'd9; wr_data = 12'h00C;
    @(negedge clk);
    inst_req = 1'b0; wr_en = 1'b0;
    shadow_install(7, 3, 1'b0);
    settle(); check_all("R8");

    // R11: random mix checked against the encoding model
    for (int it = 0; it < 200; it++) begin
      int op = int'($urandom_range(0, 4));
      case (op)
        0: begin @(negedge clk); pin_in = 16'($urandom); end
        1: do_write(2'd0, int'($urandom_range(0, M)),
                    {1'($urandom), 8'($urandom_range(0, N + 3)), ($urandom_range(0, 1) != 0) ? 3'd4 : 3'($urandom)});
        2: do_write(2'd1, int'($urandom_range(0, N)), 12'($urandom));
        3: do_write(2'd2, int'($urandom_range(0, N)), 12'($urandom));
        default: do_install(int'($urandom_range(0, N)), int'($urandom_range(0, M)), 1'($urandom));
      endcase
      settle();
      check_all("R11");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule